// File: doc/BRIEF.md
# Random Number Generator Control and Status Register File

This block is the software-facing register file of a true random number generator. A host reads and writes 32-bit registers through a simple select/write bus with byte addresses. Reads are combinational and writes take effect at the clock edge. The entropy source and its statistical tests sit outside the block. They appear here only as strobes: a 128-bit datum with a valid pulse, six per-test failure pulses, and one alarm pulse per free-running oscillator.

A new datum is held in four output words. A sticky ready flag in the status register announces it. Software reads the words and then writes 1 to the ready bit to acknowledge them. Only after that acknowledge can the next datum be loaded, so the words cannot change under a reader. Test failures latch into write-1-to-clear status bits. A registered interrupt is raised whenever an enabled status bit is set.

Oscillator alarms are counted against a programmable threshold. An alarm that arrives once the count has reached the threshold switches off the offending oscillators and records them in a stop register. It also latches a shutdown status bit and restarts the count. Software brings the oscillators back by rewriting the enable, mask and stop registers.

Top module: `rng_csr_block`

## Requirements
- R1: After reset every register reads zero, except the revision register at 0x7C and the options register at 0x78. These read their parameter values; the default revision has major 2 in bits 27:24, minor 1 in bits 23:20 and patch 3 in bits 19:16. Offsets that are not mapped read zero.
- R2: Only the defined bits can be written and read back. Control (0x14) keeps bits 10, 8 and 7:0, config (0x18) keeps bits 31:16 and 7:0, and the threshold at 0x1C keeps bits 7:0. Writes to unmapped, read-only or data offsets change nothing.
- R3: Control bit 10 enables the generator. With it set and the ready bit (status bit 0) clear, a valid strobe stores datum bits 32k+31:32k in word k at offset 4k (k = 0..3) and sets ready at the same clock edge.
- R4: While ready is set, or while the generator is disabled, valid strobes are ignored and the words keep their values. Writing 1 to status bit 0 clears ready, and the next strobe is loaded.
- R5: Failure input bit i sets status bit i+2 while the generator is enabled. The order is stuck output, noise, run, long run, poker, monobit. A bit stays set until a 1 is written to it, and a set in the same cycle as the clear wins.
- R6: `irq_o` goes high one cycle after any status bit is set whose matching control bit is also set. Control bit 0 enables the ready bit and control bits 7:1 enable status bits 7:1. It falls one cycle after the last such bit clears.
- R7: An alarm counts only for an oscillator whose enable bit (0x20) is set and whose mask bit (0x28) is clear. In a cycle with any counting alarm and a count below the threshold, the count (0x1C bits 15:8) rises by one.
- R8: A counting alarm that arrives when the count is at or above the threshold shuts down the oscillators that raised it. Their enable bits clear and their stop bits (0x2C) set, status bit 1 sets, and the count returns to zero. A threshold of 1 therefore shuts down on the second alarm.
- R9: The host restores oscillators by writing the detune (0x24), mask, stop and enable registers. After that, alarms are counted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel_i | input | 1 | Register access select |
| bus_wr_i | input | 1 | Write when high, read when low |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from the address |
| dat_valid_i | input | 1 | New datum strobe |
| dat_i | input | 128 | Datum from the post-processor |
| test_fail_i | input | 6 | Per-test failure pulses |
| osc_alarm_i | input | NUM_OSC | Per-oscillator alarm pulses |
| osc_en_o | output | NUM_OSC | Oscillator run enables |
| irq_o | output | 1 | Registered level interrupt |

## Verification
Most internal state of this block is visible on the next read. A wrong ready flag shows at once as a datum that is lost, duplicated or overwritten before the acknowledge. It shows in the output words or the status bit read right after that clock edge. A wrong alarm count only becomes visible when it decides a shutdown. Because of that, the bench reads the count back after every alarm pulse, so an off-by-one shows up in the stop and enable registers no later than the next alarm. Interrupt errors show one cycle after the status or control change, which is where the bench samples.

// File: rtl/rng_csr_pkg.sv
package rng_csr_pkg;
   localparam int WORD_W    = 32;
   localparam int NUM_WORDS = 4;
   localparam int NUM_TESTS = 6;
   localparam int STAT_W    = NUM_TESTS + 2;
   localparam int THR_W     = 8;

   // byte offsets of the register map
   localparam logic [7:0] OFS_STAT  = 8'h10;
   localparam logic [7:0] OFS_CTRL  = 8'h14;
   localparam logic [7:0] OFS_CFG   = 8'h18;
   localparam logic [7:0] OFS_ALRM  = 8'h1C;
   localparam logic [7:0] OFS_OSCEN = 8'h20;
   localparam logic [7:0] OFS_DTUNE = 8'h24;
   localparam logic [7:0] OFS_AMASK = 8'h28;
   localparam logic [7:0] OFS_ASTOP = 8'h2C;
   localparam logic [7:0] OFS_OPT   = 8'h78;
   localparam logic [7:0] OFS_REV   = 8'h7C;

   // status and control bit positions
   localparam int ST_READY     = 0;
   localparam int ST_SHUT      = 1;
   localparam int ST_TEST_LO   = 2;
   localparam int CTRL_EN_BIT  = 10;

   localparam logic [31:0] CTRL_WMASK = 32'h0000_05FF;
   localparam logic [31:0] CFG_WMASK  = 32'hFFFF_00FF;
endpackage

// File: rtl/rng_status_unit.sv
module rng_status_unit
   import rng_csr_pkg::*;
#(
   parameter int W_WORD  = WORD_W,
   parameter int N_WORDS = NUM_WORDS,
   parameter int N_TESTS = NUM_TESTS,
   localparam int DAT_W  = W_WORD * N_WORDS,
   localparam int ST_W   = N_TESTS + 2
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             gen_en_i,
   input  logic                             dat_valid_i,
   input  logic [DAT_W-1:0]                 dat_i,
   input  logic [N_TESTS-1:0]               test_fail_i,
   input  logic                             shut_evt_i,
   input  logic                             clr_wr_i,
   input  logic [ST_W-1:0]                  clr_bits_i,
   output logic [ST_W-1:0]                  status_o,
   output logic [N_WORDS-1:0][W_WORD-1:0]   words_o
);
   logic               ready_q;
   logic               shut_q;
   logic [N_TESTS-1:0] test_q;
   logic               load;
   logic [ST_W-1:0]    clr;

   assign load = dat_valid_i & gen_en_i & ~ready_q;
   assign clr  = clr_wr_i ? clr_bits_i : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ready_q <= 1'b0;
         shut_q  <= 1'b0;
         test_q  <= '0;
      end else begin
         if (load)                 ready_q <= 1'b1;
         else if (clr[ST_READY])   ready_q <= 1'b0;
         if (shut_evt_i)           shut_q  <= 1'b1;
         else if (clr[ST_SHUT])    shut_q  <= 1'b0;
         test_q <= (test_q & ~clr[ST_W-1:ST_TEST_LO])
                 | (gen_en_i ? test_fail_i : '0);
      end
   end

   for (genvar k = 0; k < N_WORDS; k++) begin : g_word
      logic [W_WORD-1:0] word_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    word_q <= '0;
         else if (load) word_q <= dat_i[k*W_WORD +: W_WORD];
      end
      assign words_o[k] = word_q;
   end

   assign status_o = {test_q, shut_q, ready_q};
endmodule

// File: rtl/rng_alarm_unit.sv
module rng_alarm_unit #(
   parameter int N_OSC = 8,
   parameter int W_THR = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_OSC-1:0] osc_alarm_i,
   input  logic [W_THR-1:0] thr_i,
   input  logic             en_wr_i,
   input  logic             mask_wr_i,
   input  logic             stop_wr_i,
   input  logic [N_OSC-1:0] wdata_i,
   output logic [N_OSC-1:0] osc_en_o,
   output logic [N_OSC-1:0] mask_o,
   output logic [N_OSC-1:0] stop_o,
   output logic [W_THR-1:0] count_o,
   output logic             shut_evt_o
);
   logic [N_OSC-1:0] en_q, mask_q, stop_q, qual;
   logic [W_THR-1:0] cnt_q;
   logic             any_alarm, trip;

   assign qual      = osc_alarm_i & en_q & ~mask_q;
   assign any_alarm = |qual;
   assign trip      = any_alarm && (cnt_q >= thr_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cnt_q <= '0;
      else if (trip)      cnt_q <= '0;
      else if (any_alarm) cnt_q <= cnt_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         mask_q <= '0;
      else if (mask_wr_i) mask_q <= wdata_i;
   end

   for (genvar i = 0; i < N_OSC; i++) begin : g_osc
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            en_q[i]   <= 1'b0;
            stop_q[i] <= 1'b0;
         end else begin
            if (trip && qual[i]) en_q[i] <= 1'b0;
            else if (en_wr_i)    en_q[i] <= wdata_i[i];
            if (trip && qual[i]) stop_q[i] <= 1'b1;
            else if (stop_wr_i)  stop_q[i] <= wdata_i[i];
         end
      end
   end

   assign osc_en_o   = en_q;
   assign mask_o     = mask_q;
   assign stop_o     = stop_q;
   assign count_o    = cnt_q;
   assign shut_evt_o = trip;
endmodule

// File: rtl/rng_csr_block.sv
module rng_csr_block
   import rng_csr_pkg::*;
#(
   parameter int          ADDR_W  = 8,
   parameter int          NUM_OSC = 8,
   parameter logic [31:0] REV_VAL = 32'h0213_0000,
   parameter logic [31:0] OPT_VAL = 32'h0000_0804,
   localparam int         DAT_W   = WORD_W * NUM_WORDS
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_sel_i,
   input  logic               bus_wr_i,
   input  logic [ADDR_W-1:0]  bus_addr_i,
   input  logic [31:0]        bus_wdata_i,
   output logic [31:0]        bus_rdata_o,
   input  logic               dat_valid_i,
   input  logic [DAT_W-1:0]   dat_i,
   input  logic [NUM_TESTS-1:0] test_fail_i,
   input  logic [NUM_OSC-1:0] osc_alarm_i,
   output logic [NUM_OSC-1:0] osc_en_o,
   output logic               irq_o
);
   if (ADDR_W < 7 || ADDR_W > 16) begin : g_bad_addr
      $error("ADDR_W must lie in 7..16");
   end
   if (NUM_OSC < 1 || NUM_OSC > 32) begin : g_bad_osc
      $error("NUM_OSC must lie in 1..32");
   end

   logic [ADDR_W-1:0] a_al;
   logic              wr_hit;
   logic [31:0]       ctrl_q, cfg_q, detune_q;
   logic [THR_W-1:0]  thr_q;
   logic [STAT_W-1:0] status_w;
   logic [NUM_WORDS-1:0][WORD_W-1:0] words_w;
   logic [NUM_OSC-1:0] en_w, mask_w, stop_w;
   logic [THR_W-1:0]  count_w;
   logic              shut_w, irq_q;

   assign a_al   = {bus_addr_i[ADDR_W-1:2], 2'b00};
   assign wr_hit = bus_sel_i & bus_wr_i;

   function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] ofs);
      return a == ADDR_W'(ofs);
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         cfg_q    <= '0;
         thr_q    <= '0;
         detune_q <= '0;
      end else if (wr_hit) begin
         if (hit(a_al, OFS_CTRL))  ctrl_q   <= bus_wdata_i & CTRL_WMASK;
         if (hit(a_al, OFS_CFG))   cfg_q    <= bus_wdata_i & CFG_WMASK;
         if (hit(a_al, OFS_ALRM))  thr_q    <= bus_wdata_i[THR_W-1:0];
         if (hit(a_al, OFS_DTUNE)) detune_q <= bus_wdata_i;
      end
   end

   rng_status_unit #(
      .W_WORD(WORD_W), .N_WORDS(NUM_WORDS), .N_TESTS(NUM_TESTS)
   ) stat_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .gen_en_i    (ctrl_q[CTRL_EN_BIT]),
      .dat_valid_i (dat_valid_i),
      .dat_i       (dat_i),
      .test_fail_i (test_fail_i),
      .shut_evt_i  (shut_w),
      .clr_wr_i    (wr_hit && hit(a_al, OFS_STAT)),
      .clr_bits_i  (bus_wdata_i[STAT_W-1:0]),
      .status_o    (status_w),
      .words_o     (words_w)
   );

   rng_alarm_unit #(
      .N_OSC(NUM_OSC), .W_THR(THR_W)
   ) alarm_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .osc_alarm_i (osc_alarm_i),
      .thr_i       (thr_q),
      .en_wr_i     (wr_hit && hit(a_al, OFS_OSCEN)),
      .mask_wr_i   (wr_hit && hit(a_al, OFS_AMASK)),
      .stop_wr_i   (wr_hit && hit(a_al, OFS_ASTOP)),
      .wdata_i     (bus_wdata_i[NUM_OSC-1:0]),
      .osc_en_o    (en_w),
      .mask_o      (mask_w),
      .stop_o      (stop_w),
      .count_o     (count_w),
      .shut_evt_o  (shut_w)
   );

   always_comb begin
      bus_rdata_o = '0;
      if (a_al[ADDR_W-1:4] == '0) begin
         bus_rdata_o = words_w[a_al[3:2]];
      end else if (hit(a_al, OFS_STAT))  bus_rdata_o = 32'(status_w);
      else if (hit(a_al, OFS_CTRL))      bus_rdata_o = ctrl_q;
      else if (hit(a_al, OFS_CFG))       bus_rdata_o = cfg_q;
      else if (hit(a_al, OFS_ALRM))      bus_rdata_o = {16'h0, count_w, thr_q};
      else if (hit(a_al, OFS_OSCEN))     bus_rdata_o = 32'(en_w);
      else if (hit(a_al, OFS_DTUNE))     bus_rdata_o = detune_q;
      else if (hit(a_al, OFS_AMASK))     bus_rdata_o = 32'(mask_w);
      else if (hit(a_al, OFS_ASTOP))     bus_rdata_o = 32'(stop_w);
      else if (hit(a_al, OFS_OPT))       bus_rdata_o = OPT_VAL;
      else if (hit(a_al, OFS_REV))       bus_rdata_o = REV_VAL;
      if (!bus_sel_i) bus_rdata_o = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= |(status_w & ctrl_q[STAT_W-1:0]);
   end

   assign irq_o    = irq_q;
   assign osc_en_o = en_w;
endmodule

// File: rtl/rng_csr_chk.sv
module rng_csr_chk #(
   parameter int NUM_OSC = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic [7:0]          status,
   input logic [31:0]         ctrl,
   input logic [127:0]        words,
   input logic                dat_valid,
   input logic                irq,
   input logic [NUM_OSC-1:0]  stop,
   input logic [7:0]          count
);
   // R3
   ready_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[0]) |-> $past(dat_valid));

   // R4
   words_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status[0] && $past(status[0])) |-> $stable(words));

   // R6
   irq_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq == $past(|(status & ctrl[7:0])));

   // R8
   shut_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[1]) |-> (stop != '0) && (count == 8'd0));

   // R7
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (count != $past(count)) |-> (count == 8'd0) || (count == $past(count) + 8'd1));
endmodule

bind rng_csr_block rng_csr_chk #(.NUM_OSC(NUM_OSC)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .status    (status_w),
   .ctrl      (ctrl_q),
   .words     (words_w),
   .dat_valid (dat_valid_i),
   .irq       (irq_o),
   .stop      (stop_w),
   .count     (count_w)
);

// File: tb/rng_csr_block_tb.sv
module rng_csr_block_tb_top;
   localparam int CLK_NS = 10;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         bus_sel = 1'b0, bus_wr = 1'b0;
   logic [7:0]   bus_addr = '0;
   logic [31:0]  bus_wdata = '0, bus_rdata;
   logic         dat_valid = 1'b0;
   logic [127:0] dat = '0;
   logic [5:0]   test_fail = '0;
   logic [7:0]   osc_alarm = '0;
   logic [7:0]   osc_en;
   logic         irq;

   int n_chk = 0, n_fail = 0;

   always #(CLK_NS/2) clk = ~clk;

   rng_csr_block dut_i (
      .clk(clk), .rst_n(rst_n), .bus_sel_i(bus_sel), .bus_wr_i(bus_wr),
      .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
      .dat_valid_i(dat_valid), .dat_i(dat), .test_fail_i(test_fail),
      .osc_alarm_i(osc_alarm), .osc_en_o(osc_en), .irq_o(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      bus_sel = 1'b0;
   endtask

   task automatic rdchk(input string req, input logic [7:0] a, input logic [31:0] exp);
      logic [31:0] v;
      rd(a, v);
      chk(req, v, exp);
   endtask

   task automatic pulse(input logic v, input logic [127:0] d,
                        input logic [5:0] tf, input logic [7:0] al);
      @(negedge clk);
      dat_valid = v; dat = d; test_fail = tf; osc_alarm = al;
      @(posedge clk); #1;
      dat_valid = 1'b0; test_fail = '0; osc_alarm = '0;
   endtask

   function automatic logic [127:0] rnd128();
      return {$urandom, $urandom, $urandom, $urandom};
   endfunction

   initial begin
      #(CLK_NS * 150000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic          m_ready;
      logic [127:0]  m_words;
      logic [31:0]   v;
      void'($urandom(32'd4242));
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      for (int k = 0; k < 12; k++) rdchk("R1 reset", 8'(k*4), 32'h0);
      rdchk("R1 revision", 8'h7C, 32'h0213_0000);
      rdchk("R1 options", 8'h78, 32'h0000_0804);
      rdchk("R1 unmapped", 8'h40, 32'h0);
      chk("R1 irq", 32'(irq), 32'h0);

      // R2 write masks and ignored writes
      wr(8'h14, 32'hFFFF_FFFF); rdchk("R2 control", 8'h14, 32'h0000_05FF);
      wr(8'h18, 32'hFFFF_FFFF); rdchk("R2 config", 8'h18, 32'hFFFF_00FF);
      wr(8'h1C, 32'hFFFF_FFFF); rdchk("R2 threshold", 8'h1C, 32'h0000_00FF);
      wr(8'h40, 32'hFFFF_FFFF); rdchk("R2 unmapped", 8'h40, 32'h0);
      wr(8'h7C, 32'h0);         rdchk("R2 revision", 8'h7C, 32'h0213_0000);
      wr(8'h04, 32'hDEAD_BEEF); rdchk("R2 data word", 8'h04, 32'h0);
      wr(8'h14, 32'h0);

      // R4 disabled generator ignores strobes
      pulse(1'b1, rnd128(), 6'h0, 8'h0);
      rdchk("R4 disabled", 8'h10, 32'h0);
      rdchk("R4 disabled word", 8'h00, 32'h0);

      // R3 R4 random datum / acknowledge traffic
      wr(8'h14, 32'h0000_0400);
      m_ready = 1'b0; m_words = '0;
      for (int i = 0; i < 300; i++) begin
         logic          sv, sa;
         logic [127:0]  sd;
         int            k;
         sv = ($urandom % 2) == 0;
         sa = ($urandom % 3) == 0;
         sd = rnd128();
         @(negedge clk);
         dat_valid = sv; dat = sd;
         if (sa) begin
            bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h10; bus_wdata = 32'h1;
         end
         @(posedge clk); #1;
         dat_valid = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
         if (sv && !m_ready) begin
            m_ready = 1'b1; m_words = sd;
         end else if (sa) begin
            m_ready = 1'b0;
         end
         rdchk("R3 R4 ready", 8'h10, 32'(m_ready));
         k = $urandom % 4;
         rdchk("R3 R4 word", 8'(k*4), m_words[k*32 +: 32]);
      end

      // R5 failure latching
      wr(8'h10, 32'hFF);
      pulse(1'b0, '0, 6'b000001, 8'h0);
      rdchk("R5 stuck", 8'h10, 32'h04);
      pulse(1'b0, '0, 6'b100000, 8'h0);
      rdchk("R5 monobit", 8'h10, 32'h84);
      wr(8'h10, 32'h80);
      rdchk("R5 clear", 8'h10, 32'h04);
      @(negedge clk);
      test_fail = 6'b000001;
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h10; bus_wdata = 32'h04;
      @(posedge clk); #1;
      test_fail = '0; bus_sel = 1'b0; bus_wr = 1'b0;
      rdchk("R5 set wins", 8'h10, 32'h04);

      // R6 interrupt
      @(posedge clk); #1;
      chk("R6 masked", 32'(irq), 32'h0);
      wr(8'h14, 32'h0000_0404);
      chk("R6 lag", 32'(irq), 32'h0);
      @(posedge clk); #1;
      chk("R6 raise", 32'(irq), 32'h1);
      wr(8'h10, 32'h04);
      chk("R6 hold", 32'(irq), 32'h1);
      @(posedge clk); #1;
      chk("R6 drop", 32'(irq), 32'h0);
      wr(8'h14, 32'h0000_0401);
      m_words = rnd128();
      pulse(1'b1, m_words, 6'h0, 8'h0);
      chk("R6 ready lag", 32'(irq), 32'h0);
      @(posedge clk); #1;
      chk("R6 ready irq", 32'(irq), 32'h1);
      wr(8'h10, 32'h01);
      wr(8'h14, 32'h0000_0400);

      // R7 R8 alarm counting and shutdown
      wr(8'h1C, 32'h1);
      wr(8'h20, 32'hFF);
      rdchk("R9 enable", 8'h20, 32'hFF);
      chk("R9 osc_en", 32'(osc_en), 32'hFF);
      pulse(1'b0, '0, 6'h0, 8'h08);
      rdchk("R7 count", 8'h1C, 32'h0101);
      pulse(1'b0, '0, 6'h0, 8'h08);
      rdchk("R8 stop", 8'h2C, 32'h08);
      rdchk("R8 enable", 8'h20, 32'hF7);
      rdchk("R8 count", 8'h1C, 32'h0001);
      rd(8'h10, v);
      chk("R8 status", v & 32'h2, 32'h2);
      pulse(1'b0, '0, 6'h0, 8'h08);
      rdchk("R7 stopped osc", 8'h1C, 32'h0001);
      wr(8'h28, 32'h01);
      pulse(1'b0, '0, 6'h0, 8'h01);
      rdchk("R7 masked", 8'h1C, 32'h0001);

      // R9 recovery
      wr(8'h24, 32'h08);
      wr(8'h28, 32'h0);
      wr(8'h2C, 32'h0);
      wr(8'h20, 32'hFF);
      wr(8'h10, 32'h02);
      rdchk("R9 detune", 8'h24, 32'h08);
      rdchk("R9 stop", 8'h2C, 32'h0);
      rdchk("R9 enable", 8'h20, 32'hFF);
      rdchk("R9 status", 8'h10, 32'h0);
      pulse(1'b0, '0, 6'h0, 8'h08);
      rdchk("R9 counting", 8'h1C, 32'h0101);

      // R8 threshold zero, two oscillators
      wr(8'h1C, 32'h0);
      pulse(1'b0, '0, 6'h0, 8'h10);
      rdchk("R8 thr0 stop", 8'h2C, 32'h10);
      rdchk("R8 thr0 count", 8'h1C, 32'h0);
      pulse(1'b0, '0, 6'h0, 8'h03);
      rdchk("R8 pair stop", 8'h2C, 32'h13);
      rdchk("R8 pair enable", 8'h20, 32'hEC);
      chk("R8 osc_en", 32'(osc_en), 32'hEC);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule